// File: doc/BRIEF.md
# Zero-Run Loss-of-Signal Monitor with Rail Muting

This block watches a dual-rail recovered data stream, one bit period per clock, where a bit period counts as a one when either rail is high. A long run of zeros raises a digital loss flag. The flag drops only after the pulse density has stayed healthy for several fixed measurement windows in a row. That hysteresis keeps a marginal line from toggling the alarm.

The digital flag is combined with an externally detected analog loss indication into one overall loss output. A local loopback request forces that output true. When muting is enabled, both rails of the registered data output are held low while the overall loss output is true. Each disable bit masks its own source. Setting both disables therefore suppresses the loss output, except during loopback.

Top module: `loss_monitor_top`

## Requirements
- R1: With the digital disable low and the flag clear, the digital flag (`digLossStatus`) goes to 1 after the clock edge that samples the 160th consecutive zero bit period (parameter `ZERO_LIMIT`). A bit period is a one when `rxPos` or `rxNeg` is 1. After 159 zeros the flag stays 0.
- R2: Any one bit period restarts the zero count, so two zero runs separated by a one do not add up.
- R3: Once declared, the flag clears after the edge that ends the fourth back-to-back 32-bit window holding at least 10 ones. The first window begins with the first bit sampled after the declaration edge, or after reset. The flag is still 1 one bit before that edge.
- R4: A window holding fewer than 10 ones restarts the count of good windows from zero.
- R5: While `digDisable` is 1, `digLossStatus` is 0 in the same cycle, whatever the input data.
- R6: `lossOut` is 1 when `digLossStatus` is 1, or when `anaLossIn` is 1 and `anaDisable` is 0. With both disables set and no loopback request, `lossOut` is 0.
- R7: While `loopbackReq` is 1, `lossOut` is 1.
- R8: When `muteEnable` and `lossOut` are both 1 in a cycle, `outPos` and `outNeg` are 0 after the next edge. Data passes again once loss clears.
- R9: When not muted, `outPos` and `outNeg` equal the rail inputs sampled at the previous clock edge.
- R10: Synchronous active-high reset leaves `digLossStatus` at 1, with `outPos` and `outNeg` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst | input | 1 | Synchronous active-high reset |
| rxPos | input | 1 | Positive-rail recovered data |
| rxNeg | input | 1 | Negative-rail recovered data |
| anaLossIn | input | 1 | Analog loss indication from the front end |
| anaDisable | input | 1 | Masks the analog loss indication |
| digDisable | input | 1 | Disables the zero-run detector |
| muteEnable | input | 1 | Enables muting of both rails during loss |
| loopbackReq | input | 1 | Local loopback selected; forces loss |
| outPos | output | 1 | Registered positive-rail data |
| outNeg | output | 1 | Registered negative-rail data |
| lossOut | output | 1 | Combined loss-of-signal |
| digLossStatus | output | 1 | Digital loss flag for host polling |

## Verification
The assertions check the combinational rules on every cycle: the disable gating, the loopback override, the both-disabled suppression, muting one cycle after a muted cycle, and plain one-cycle pass-through. They also check that a cycle holding a one never raises the flag. The exact run length that declares loss, and the restart of that count on a one, can only be shown by the bench scenarios. The same holds for the window alignment, the four-good-window release and its restart on a weak window.

// File: rtl/loss_mon_pkg.sv
package loss_mon_pkg;

  // Control to datapath: what the window counters should do this cycle
  typedef struct packed {
    logic winRun;    // count bits into the current window
    logic winClear;  // hold all window counters at zero
  } winStrobe_t;

  // Datapath to control: events seen on the current bit
  typedef struct packed {
    logic zeroHit;   // this zero completes the declaring run
    logic winEnd;    // this bit is the last of a window
    logic winGood;   // the window ending now has enough ones
    logic lastGood;  // enough good windows already preceded it
  } detEvents_t;

endpackage

// File: rtl/loss_mon_datapath.sv
module loss_mon_datapath
  import loss_mon_pkg::*;
#(
  parameter int ZERO_LIMIT = 160,
  parameter int WIN_LEN    = 32,
  parameter int MIN_ONES   = 10,
  parameter int GOOD_WINS  = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rxPos,
  input  logic       rxNeg,
  input  logic       anaLossIn,
  input  logic       anaDisable,
  input  logic       loopbackReq,
  input  logic       muteEnable,
  input  logic       digLossFlag,
  input  winStrobe_t strobe,
  output detEvents_t events,
  output logic       outPos,
  output logic       outNeg,
  output logic       lossOut
);

  localparam int ZW = $clog2(ZERO_LIMIT + 1);
  localparam int PW = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam int OW = $clog2(WIN_LEN + 1);
  localparam int GW = (GOOD_WINS > 1) ? $clog2(GOOD_WINS) : 1;
  localparam logic [ZW-1:0] ZERO_MAX  = ZW'(ZERO_LIMIT);
  localparam logic [ZW-1:0] ZERO_LAST = ZW'(ZERO_LIMIT - 1);
  localparam logic [PW-1:0] POS_LAST  = PW'(WIN_LEN - 1);
  localparam logic [OW-1:0] ONES_MAX  = OW'(WIN_LEN);
  localparam logic [OW-1:0] ONES_MIN  = OW'(MIN_ONES);
  localparam logic [GW-1:0] GOOD_LAST = GW'(GOOD_WINS - 1);

  logic          lineBit;
  logic [ZW-1:0] zeroRun;
  logic [PW-1:0] winPos;
  logic [OW-1:0] onesCnt;
  logic [OW-1:0] onesPlus;
  logic [GW-1:0] goodCnt;
  logic          muteNow;

  assign lineBit = rxPos | rxNeg;

  // Consecutive-zero run, saturating at the declare limit
  always_ff @(posedge clk) begin
    if (rst || lineBit)         zeroRun <= '0;
    else if (zeroRun != ZERO_MAX) zeroRun <= zeroRun + 1'b1;
  end

  assign onesPlus = (onesCnt == ONES_MAX) ? onesCnt : onesCnt + OW'(lineBit);

  assign events.zeroHit  = !lineBit && (zeroRun >= ZERO_LAST);
  assign events.winEnd   = (winPos == POS_LAST);
  assign events.winGood  = (onesPlus >= ONES_MIN);
  assign events.lastGood = (goodCnt == GOOD_LAST);

  // Density windows used for release
  always_ff @(posedge clk) begin
    if (rst || strobe.winClear) begin
      winPos  <= '0;
      onesCnt <= '0;
      goodCnt <= '0;
    end else if (strobe.winRun) begin
      if (events.winEnd) begin
        winPos  <= '0;
        onesCnt <= '0;
        if (!events.winGood)       goodCnt <= '0;
        else if (!events.lastGood) goodCnt <= goodCnt + 1'b1;
      end else begin
        winPos  <= winPos + 1'b1;
        onesCnt <= onesPlus;
      end
    end
  end

  // Combined loss and registered, optionally muted, data
  assign lossOut = loopbackReq | (anaLossIn & ~anaDisable) | digLossFlag;
  assign muteNow = muteEnable & lossOut;

  always_ff @(posedge clk) begin
    if (rst || muteNow) begin
      outPos <= 1'b0;
      outNeg <= 1'b0;
    end else begin
      outPos <= rxPos;
      outNeg <= rxNeg;
    end
  end

endmodule

// File: rtl/loss_mon_ctrl.sv
module loss_mon_ctrl
  import loss_mon_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       digDisable,
  input  detEvents_t events,
  output winStrobe_t strobe,
  output logic       digLossFlag
);

  logic lossReg;

  always_ff @(posedge clk) begin
    if (rst)
      lossReg <= 1'b1;
    else if (digDisable)
      lossReg <= 1'b0;
    else if (!lossReg && events.zeroHit)
      lossReg <= 1'b1;
    else if (lossReg && events.winEnd && events.winGood && events.lastGood)
      lossReg <= 1'b0;
  end

  assign strobe.winRun   = lossReg;
  assign strobe.winClear = ~lossReg;
  assign digLossFlag     = lossReg & ~digDisable;

endmodule

// File: rtl/loss_monitor_top.sv
module loss_monitor_top
  import loss_mon_pkg::*;
#(
  parameter int ZERO_LIMIT = 160,
  parameter int WIN_LEN    = 32,
  parameter int MIN_ONES   = 10,
  parameter int GOOD_WINS  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic rxPos,
  input  logic rxNeg,
  input  logic anaLossIn,
  input  logic anaDisable,
  input  logic digDisable,
  input  logic muteEnable,
  input  logic loopbackReq,
  output logic outPos,
  output logic outNeg,
  output logic lossOut,
  output logic digLossStatus
);

  winStrobe_t strobe;
  detEvents_t events;

  loss_mon_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .digDisable  (digDisable),
    .events      (events),
    .strobe      (strobe),
    .digLossFlag (digLossStatus)
  );

  loss_mon_datapath #(
    .ZERO_LIMIT (ZERO_LIMIT),
    .WIN_LEN    (WIN_LEN),
    .MIN_ONES   (MIN_ONES),
    .GOOD_WINS  (GOOD_WINS)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .rxPos       (rxPos),
    .rxNeg       (rxNeg),
    .anaLossIn   (anaLossIn),
    .anaDisable  (anaDisable),
    .loopbackReq (loopbackReq),
    .muteEnable  (muteEnable),
    .digLossFlag (digLossStatus),
    .strobe      (strobe),
    .events      (events),
    .outPos      (outPos),
    .outNeg      (outNeg),
    .lossOut     (lossOut)
  );

endmodule

// File: rtl/loss_mon_checker.sv
module loss_mon_checker (
  input logic clk,
  input logic rst,
  input logic rxPos,
  input logic rxNeg,
  input logic anaLossIn,
  input logic anaDisable,
  input logic digDisable,
  input logic muteEnable,
  input logic loopbackReq,
  input logic outPos,
  input logic outNeg,
  input logic lossOut,
  input logic digLossStatus
);

  assert_one_never_declares_R1: assert property (@(posedge clk) disable iff (rst)
    (!digLossStatus && !digDisable && (rxPos || rxNeg)) |=> !digLossStatus);

  assert_disable_masks_R5: assert property (@(posedge clk) disable iff (rst)
    digDisable |-> !digLossStatus);

  assert_digital_feeds_loss_R6: assert property (@(posedge clk) disable iff (rst)
    digLossStatus |-> lossOut);

  assert_both_disabled_R6: assert property (@(posedge clk) disable iff (rst)
    (anaDisable && digDisable && !loopbackReq) |-> !lossOut);

  assert_loopback_forces_R7: assert property (@(posedge clk) disable iff (rst)
    loopbackReq |-> lossOut);

  assert_mute_rails_R8: assert property (@(posedge clk) disable iff (rst)
    (muteEnable && lossOut) |=> (!outPos && !outNeg));

  assert_pass_through_R9: assert property (@(posedge clk) disable iff (rst)
    !(muteEnable && lossOut) |=> (outPos == $past(rxPos) && outNeg == $past(rxNeg)));

endmodule

bind loss_monitor_top loss_mon_checker u_chk (
  .clk           (clk),
  .rst           (rst),
  .rxPos         (rxPos),
  .rxNeg         (rxNeg),
  .anaLossIn     (anaLossIn),
  .anaDisable    (anaDisable),
  .digDisable    (digDisable),
  .muteEnable    (muteEnable),
  .loopbackReq   (loopbackReq),
  .outPos        (outPos),
  .outNeg        (outNeg),
  .lossOut       (lossOut),
  .digLossStatus (digLossStatus)
);

// File: tb/sim_loss_monitor_top.sv
`timescale 1ns/1ps
module sim_loss_monitor_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rxPos = 1'b0, rxNeg = 1'b0;
  logic anaLossIn = 1'b0, anaDisable = 1'b0, digDisable = 1'b0;
  logic muteEnable = 1'b0, loopbackReq = 1'b0;
  logic outPos, outNeg, lossOut, digLossStatus;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  loss_monitor_top u0 (
    .clk(clk), .rst(rst), .rxPos(rxPos), .rxNeg(rxNeg),
    .anaLossIn(anaLossIn), .anaDisable(anaDisable), .digDisable(digDisable),
    .muteEnable(muteEnable), .loopbackReq(loopbackReq),
    .outPos(outPos), .outNeg(outNeg), .lossOut(lossOut),
    .digLossStatus(digLossStatus)
  );

  // {expected flag, zero run length}, each from a freshly cleared state
  localparam logic [9:0] RUN_TABLE [6] = '{
    {1'b0, 9'd159}, {1'b1, 9'd160}, {1'b1, 9'd161},
    {1'b0, 9'd1},   {1'b0, 9'd100}, {1'b1, 9'd255}
  };

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Apply one bit period, then move just past the sampling edge
  task automatic sendBit(input logic p, input logic n);
    rxPos = p;
    rxNeg = n;
    @(posedge clk);
    #1;
  endtask

  task automatic sendZeros(input int count);
    for (int i = 0; i < count; i++) sendBit(1'b0, 1'b0);
  endtask

  // One window; ones placed at its tail so it ends on a one
  task automatic sendWindow(input int ones);
    for (int i = 0; i < 32; i++) sendBit(i >= 32 - ones, 1'b0);
  endtask

  task automatic doReset();
    rst = 1'b1;
    rxPos = 1'b0;
    rxNeg = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
  endtask

  task automatic clearLoss();
    for (int w = 0; w < 4; w++) sendWindow(16);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    // R10: reset state
    doReset();
    check("R10 status after reset", digLossStatus, 1'b1);
    check("R10 outPos after reset", outPos, 1'b0);
    check("R10 outNeg after reset", outNeg, 1'b0);
    check("R6 loss follows digital flag", lossOut, 1'b1);

    // Table walk: R1 threshold, R2 short runs
    for (int k = 0; k < 6; k++) begin
      doReset();
      clearLoss();
      check("R3 cleared by four good windows", digLossStatus, 1'b0);
      sendZeros(int'(RUN_TABLE[k][8:0]));
      check($sformatf("R1 run of %0d zeros", RUN_TABLE[k][8:0]),
            digLossStatus, RUN_TABLE[k][9]);
    end

    // R2: a one splits the run
    doReset();
    clearLoss();
    sendZeros(100);
    sendBit(1'b0, 1'b1);
    sendZeros(100);
    check("R2 one restarts zero count", digLossStatus, 1'b0);
    sendZeros(60);
    check("R2 fresh run reaches limit", digLossStatus, 1'b1);

    // R3: exact release point, with a window of exactly ten ones
    doReset();
    for (int w = 0; w < 3; w++) sendWindow(16);
    for (int i = 0; i < 31; i++) sendBit(i >= 22, 1'b0);
    check("R3 still set one bit early", digLossStatus, 1'b1);
    sendBit(1'b1, 1'b0);
    check("R3 clears on fourth window end", digLossStatus, 1'b0);

    // R4: a weak window restarts the good count
    doReset();
    for (int w = 0; w < 3; w++) sendWindow(16);
    sendWindow(9);
    for (int w = 0; w < 3; w++) sendWindow(16);
    check("R4 weak window restarts count", digLossStatus, 1'b1);
    sendWindow(10);
    check("R4 release after four fresh good", digLossStatus, 1'b0);

    // R3: windows aligned to bit after declaration
    sendZeros(160);
    check("R1 redeclared", digLossStatus, 1'b1);
    clearLoss();
    check("R3 windows aligned after declaration", digLossStatus, 1'b0);

    // R9: plain pass-through
    sendBit(1'b1, 1'b0);
    check("R9 outPos one cycle later", outPos, 1'b1);
    check("R9 outNeg one cycle later", outNeg, 1'b0);
    sendBit(1'b0, 1'b1);
    check("R9 outPos follows", outPos, 1'b0);
    check("R9 outNeg follows", outNeg, 1'b1);

    // R5, R6, R7
    digDisable = 1'b1;
    #1;
    check("R5 disable clears status", digLossStatus, 1'b0);
    sendZeros(200);
    check("R5 disabled after long zero run", digLossStatus, 1'b0);
    check("R6 no loss with quiet analog", lossOut, 1'b0);
    anaLossIn = 1'b1;
    #1;
    check("R6 analog loss seen", lossOut, 1'b1);
    anaDisable = 1'b1;
    #1;
    check("R6 both disabled suppresses loss", lossOut, 1'b0);
    loopbackReq = 1'b1;
    #1;
    check("R7 loopback forces loss", lossOut, 1'b1);

    // R8: muting under forced loss, then resuming
    muteEnable = 1'b1;
    sendBit(1'b1, 1'b1);
    check("R8 outPos muted", outPos, 1'b0);
    check("R8 outNeg muted", outNeg, 1'b0);
    loopbackReq = 1'b0;
    sendBit(1'b1, 1'b1);
    check("R8 outPos resumes", outPos, 1'b1);
    check("R8 outNeg resumes", outNeg, 1'b1);

    // R8: muting from the digital flag after reset
    anaLossIn = 1'b0;
    anaDisable = 1'b0;
    digDisable = 1'b0;
    doReset();
    sendBit(1'b1, 1'b0);
    check("R8 muted while declared", outPos, 1'b0);
    clearLoss();
    sendBit(1'b1, 1'b0);
    check("R8 data passes after clearance", outPos, 1'b1);

    finishRun();
  end

endmodule